// File: doc/BRIEF.md
# Serial Program-Mode Command Slave

This block is the target side of a two-wire programming port. A host supplies a slow serial clock and a data line. The block samples both in the fast system clock domain and collects six-bit commands. Each command produces a one-cycle strobe toward the memory controller.

Two of the commands carry a sixteen-clock data frame. The first and last clocks of that frame are framing slots. For a write-type frame (Load), the block gathers fourteen payload bits and hands the word to the controller. For a read-type frame (Read), it asks the controller for a word and serialises it back. It drives the data line only while the payload bits are on it.

Program-mode entry is outside the block; it sees only a mode enable. The host is trusted to keep the required gaps between frames.

Top module: `prog_serial_slave`

## Requirements
- R1: A command is six serial clocks long. Each bit is taken on a falling edge of the serial clock, first bit as bit 0. The command is decoded right after its sixth falling edge.
- R2: Only command bits 3:0 are decoded; bits 5:4 have no effect. The non-data codes are 4'h6 (incr_stb), 4'h8 (begin_stb), 4'hE (end_stb) and 4'h9 (erase_stb). Each gives exactly one system-clock pulse per command.
- R3: Any other code (not 2, 4, 6, 8, 9 or E) raises no strobe. The following six serial clocks are again taken as a command.
- R4: Code 4'h2 (Load) is followed by a 16-clock frame. The values on clocks 1 and 16 are ignored. Clocks 2 to 15 carry load_word bits 0 to 13 in that order. After the 16th falling edge, load_stb pulses once and load_word holds the new word.
- R5: Code 4'h4 (Read) pulses read_stb once at decode. read_word is captured at the rising edge of data clock 1.
- R6: During a Read frame, sdat_oe rises at the rising edge of data clock 2 and falls at the rising edge of data clock 16. At the rising edge of clock k (k = 2 to 15), sdat_out presents bit k-2 of the captured word. Each bit therefore stays valid until the falling edge of that clock.
- R7: At most one operation strobe is high in any cycle.
- R8: While mode_en is low, the frame state is cleared and sdat_oe is low. The next serial clocks after mode_en returns are taken as a fresh command.
- R9: After a Load or Read frame ends, the next six serial clocks form a command.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| mode_en | input | 1 | Program mode active |
| sclk_in | input | 1 | Serial clock from host (asynchronous) |
| sdat_in | input | 1 | Serial data from the line (asynchronous) |
| sdat_out | output | 1 | Serial data to drive on the line |
| sdat_oe | output | 1 | Line driver enable |
| load_stb | output | 1 | Load word is ready |
| load_word | output | 14 | Last loaded word |
| read_stb | output | 1 | Read command decoded |
| read_word | input | 14 | Word to send back for Read |
| incr_stb | output | 1 | Increment-address command |
| begin_stb | output | 1 | Begin-programming command |
| end_stb | output | 1 | End-programming command |
| erase_stb | output | 1 | Bulk-erase command |

## Verification
A change on a serial pin passes two synchronizer flops and then the edge-detect comparison. Strobes, load_word and the line driver therefore change three system cycles after the serial edge that causes them.

The bench holds each serial clock phase for eight system cycles. It samples sdat_oe and sdat_out at the end of the high phase, when the value launched at that rising edge has settled and before the falling edge that consumes it. Strobes are counted by a monitor on every cycle and compared after each command, so a missing, extra or misdirected pulse is caught whatever its exact cycle.

// File: rtl/prog_serial_slave.sv
module prog_serial_slave #(
  parameter int DATA_W = 14,
  parameter int CMD_W  = 6,
  parameter int SYNC_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              mode_en,
  input  logic              sclk_in,
  input  logic              sdat_in,
  output logic              sdat_out,
  output logic              sdat_oe,
  output logic              load_stb,
  output logic [DATA_W-1:0] load_word,
  output logic              read_stb,
  input  logic [DATA_W-1:0] read_word,
  output logic              incr_stb,
  output logic              begin_stb,
  output logic              end_stb,
  output logic              erase_stb
);
  localparam int FRAME = DATA_W + 2;
  localparam int CNT_W = $clog2(FRAME);
  localparam logic [CNT_W-1:0] LAST_CMD = CNT_W'(CMD_W - 1);
  localparam logic [CNT_W-1:0] LAST_DAT = CNT_W'(FRAME - 1);
  localparam logic [3:0] OP_LOAD = 4'h2, OP_READ = 4'h4, OP_INCR = 4'h6,
                         OP_BEGIN = 4'h8, OP_ERASE = 4'h9, OP_END = 4'hE;

  typedef enum logic [1:0] {ST_CMD, ST_LOAD, ST_READ} st_t;

  logic [SYNC_W-1:0] ck_sync, dt_sync;
  logic              ck_prev;
  st_t               st;
  logic [CNT_W-1:0]  cnt;
  logic [CMD_W-1:0]  cmd_sh;
  logic [DATA_W-1:0] ld_sh, rd_sh;

  wire ck_now = ck_sync[SYNC_W-1];
  wire dt_now = dt_sync[SYNC_W-1];
  wire fall_e = ck_prev & ~ck_now;
  wire rise_e = ~ck_prev & ck_now;
  wire [CMD_W-1:0] cmd_next = {dt_now, cmd_sh[CMD_W-1:1]};
  wire [3:0] op = cmd_next[3:0];

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      ck_sync <= '0;
      dt_sync <= '0;
      ck_prev <= 1'b0;
    end else begin
      ck_sync <= {ck_sync[SYNC_W-2:0], sclk_in};
      dt_sync <= {dt_sync[SYNC_W-2:0], sdat_in};
      ck_prev <= ck_now;
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      st <= ST_CMD;
      cnt <= '0;
      cmd_sh <= '0;
      ld_sh <= '0;
      rd_sh <= '0;
      load_word <= '0;
      sdat_out <= 1'b0;
      sdat_oe <= 1'b0;
      {load_stb, read_stb, incr_stb, begin_stb, end_stb, erase_stb} <= '0;
    end else begin
      {load_stb, read_stb, incr_stb, begin_stb, end_stb, erase_stb} <= '0;
      if (!mode_en) begin
        st <= ST_CMD;
        cnt <= '0;
        sdat_oe <= 1'b0;
        sdat_out <= 1'b0;
      end else begin
        case (st)
          ST_CMD:
            if (fall_e) begin
              cmd_sh <= cmd_next;
              if (cnt == LAST_CMD) begin
                cnt <= '0;
                case (op)
                  OP_LOAD:  st <= ST_LOAD;
                  OP_READ:  begin st <= ST_READ; read_stb <= 1'b1; end
                  OP_INCR:  incr_stb <= 1'b1;
                  OP_BEGIN: begin_stb <= 1'b1;
                  OP_END:   end_stb <= 1'b1;
                  OP_ERASE: erase_stb <= 1'b1;
                  default:  ;
                endcase
              end else begin
                cnt <= cnt + 1'b1;
              end
            end
          ST_LOAD:
            if (fall_e) begin
              if (cnt == LAST_DAT) begin
                load_word <= ld_sh;
                load_stb <= 1'b1;
                st <= ST_CMD;
                cnt <= '0;
              end else begin
                if (cnt != '0) ld_sh <= {dt_now, ld_sh[DATA_W-1:1]};
                cnt <= cnt + 1'b1;
              end
            end
          ST_READ: begin
            if (rise_e) begin
              if (cnt == '0) rd_sh <= read_word;
              else if (cnt == LAST_DAT) sdat_oe <= 1'b0;
              else begin
                sdat_oe <= 1'b1;
                sdat_out <= rd_sh[0];
                rd_sh <= rd_sh >> 1;
              end
            end
            if (fall_e) begin
              if (cnt == LAST_DAT) begin
                st <= ST_CMD;
                cnt <= '0;
              end else begin
                cnt <= cnt + 1'b1;
              end
            end
          end
          default: st <= ST_CMD;
        endcase
      end
    end

  p_one_strobe_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({load_stb, read_stb, incr_stb, begin_stb, end_stb, erase_stb}));
  p_release_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !mode_en |=> !sdat_oe);
  p_oe_on_rise_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sdat_oe) |-> $past(rise_e));
  p_oe_off_rise_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(sdat_oe) && $past(mode_en)) |-> $past(rise_e));
  p_oe_only_read_r6: assert property (@(posedge clk) disable iff (!rst_n)
    sdat_oe |-> (st == ST_READ));
  p_load_on_fall_r4: assert property (@(posedge clk) disable iff (!rst_n)
    load_stb |-> $past(fall_e));
  p_cmd_on_fall_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (read_stb || incr_stb || begin_stb || end_stb || erase_stb) |-> $past(fall_e));
endmodule

// File: tb/tb_prog_serial_slave.sv
module tb_prog_serial_slave;
  localparam int H = 8;
  logic clk = 1'b0, rst_n = 1'b0, mode_en = 1'b0, sclk = 1'b0, sdat = 1'b0;
  logic sdat_out, sdat_oe, load_stb, read_stb, incr_stb, begin_stb, end_stb, erase_stb;
  logic [13:0] load_word, rd_word = '0;
  int errors = 0, checks = 0;
  int n_load = 0, n_read = 0, n_incr = 0, n_begin = 0, n_end = 0, n_erase = 0;
  bit done = 0;

  always #5 clk = ~clk;

  prog_serial_slave dut (
    .clk(clk), .rst_n(rst_n), .mode_en(mode_en), .sclk_in(sclk), .sdat_in(sdat),
    .sdat_out(sdat_out), .sdat_oe(sdat_oe), .load_stb(load_stb), .load_word(load_word),
    .read_stb(read_stb), .read_word(rd_word), .incr_stb(incr_stb), .begin_stb(begin_stb),
    .end_stb(end_stb), .erase_stb(erase_stb));

  always @(posedge clk) if (rst_n) begin
    n_load  <= n_load + int'(load_stb);
    n_read  <= n_read + int'(read_stb);
    n_incr  <= n_incr + int'(incr_stb);
    n_begin <= n_begin + int'(begin_stb);
    n_end   <= n_end + int'(end_stb);
    n_erase <= n_erase + int'(erase_stb);
  end

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic send_bit(input logic b);
    sdat = b; sclk = 1'b1; tick(H);
    sclk = 1'b0; tick(H);
  endtask

  task automatic send_cmd(input logic [5:0] c);
    for (int i = 0; i < 6; i++) send_bit(c[i]);
  endtask

  function automatic int snap();
    return n_load + 16 * n_read + 256 * n_incr + 4096 * n_begin + 65536 * n_end + 1048576 * n_erase;
  endfunction

  task automatic t_reset();
    check(sdat_oe == 0, "R8 reset oe", int'(sdat_oe), 0);
    check(load_word == 0, "R4 reset load_word", int'(load_word), 0);
    check(snap() == 0, "R7 reset strobes", snap(), 0);
  endtask

  task automatic t_plain(input logic [5:0] c, input int weight, input string req);
    int s0 = snap();
    send_cmd(c);
    check(snap() == s0 + weight, req, snap() - s0, weight);
  endtask

  task automatic t_load(input logic [13:0] w);
    int s0 = snap();
    send_cmd(6'b010010);
    send_bit(~w[0]);
    for (int i = 0; i < 14; i++) send_bit(w[i]);
    send_bit(~w[13]);
    check(snap() == s0 + 1, "R4 load strobe count", snap() - s0, 1);
    check(load_word == w, "R4 load word", int'(load_word), int'(w));
  endtask

  task automatic t_read(input logic [13:0] w);
    int s0 = snap();
    logic [13:0] got = '0;
    bit oe_ok = 1;
    rd_word = w;
    send_cmd(6'b100100);
    check(snap() == s0 + 16, "R5 read strobe", snap() - s0, 16);
    for (int k = 1; k <= 16; k++) begin
      sdat = 1'b0; sclk = 1'b1; tick(H);
      if (k == 1 || k == 16) begin
        if (sdat_oe) oe_ok = 0;
      end else begin
        if (!sdat_oe) oe_ok = 0;
        got[k-2] = sdat_out;
      end
      if (k == 1) rd_word = ~w;
      sclk = 1'b0; tick(H);
    end
    check(oe_ok, "R6 drive window", int'(oe_ok), 1);
    check(got == w, "R6 read bits", int'(got), int'(w));
    check(sdat_oe == 0, "R6 released after frame", int'(sdat_oe), 0);
  endtask

  task automatic t_unknown();
    int s0 = snap();
    send_cmd(6'b000000);
    send_cmd(6'b111111);
    send_cmd(6'b000011);
    check(snap() == s0, "R3 unknown codes", snap() - s0, 0);
    t_plain(6'b000110, 256, "R3 command after unknown");
  endtask

  task automatic t_abort();
    int s0;
    send_cmd(6'b000010);
    for (int i = 0; i < 5; i++) send_bit(1'b1);
    mode_en = 1'b0; tick(6); mode_en = 1'b1; tick(4);
    s0 = snap();
    send_cmd(6'b001000);
    check(snap() == s0 + 4096, "R8 load aborted, fresh command", snap() - s0, 4096);
    rd_word = 14'h3FFF;
    send_cmd(6'b000100);
    for (int i = 0; i < 4; i++) send_bit(1'b0);
    sclk = 1'b1; tick(H);
    check(sdat_oe == 1, "R6 driving mid read", int'(sdat_oe), 1);
    mode_en = 1'b0; tick(4);
    check(sdat_oe == 0, "R8 release on exit", int'(sdat_oe), 0);
    sclk = 1'b0; tick(H);
    mode_en = 1'b1; tick(4);
    s0 = snap();
    send_cmd(6'b001001);
    check(snap() == s0 + 1048576, "R8 erase after abort", snap() - s0, 1048576);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    tick(4);
    t_reset();
    rst_n = 1'b1; mode_en = 1'b1; tick(4);
    t_plain(6'b000110, 256, "R2 incr");
    t_plain(6'b110110, 256, "R2 incr upper bits set");
    t_plain(6'b101000, 4096, "R2 begin");
    t_plain(6'b001110, 65536, "R2 end");
    t_plain(6'b011001, 1048576, "R2 erase");
    t_plain(6'b100110, 256, "R1 bit order");
    t_unknown();
    t_load(14'h2A5C);
    t_load(14'h0001);
    t_load(14'h2000);
    t_plain(6'b000110, 256, "R9 command after load");
    t_read(14'h1B37);
    t_read(14'h2001);
    t_plain(6'b001110, 65536, "R9 command after read");
    t_abort();
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule